// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block decides, every cycle, whether the instruction in the decode stage of a five-stage in-order pipeline may advance, and where its operands must come from. It compares the decode instruction's two source register numbers, together with flags saying whether each source feeds the ALU or a branch/register-jump comparison resolved in decode, against the destination, write enable and load flag of the instructions in the execute and memory stages. From that it drives operand selects for the ALU, bypass selects for the decode-stage branch comparator, a stall, a branch-stall indication, the hold and bubble controls for the neighbouring pipeline registers, and a count of stalled cycles.

Three handling modes are chosen by a two-bit input: off (no hazard detection; the compiler is trusted to schedule around hazards), stall-only (every dependency on a later stage waits until the writeback stage supplies the value through the register file), and stall-with-forwarding (results are bypassed wherever the value already exists). An instruction in execute or memory that is marked as serializing stalls the pipeline in every mode. The reset input is expected to be already synchronized to `clk` upstream.

Top module: `hazard_unit`

## Requirements
- R1: A stage whose destination register number is 0 never causes a stall, an ALU operand select or a branch bypass.
- R2: A dependency exists only when the later stage has its write enable set and its destination equals a decode source whose need flag (ALU or branch) is set; otherwise that source gets select 0 and causes no stall.
- R3: With `mode_i` equal to 2'b00 or 2'b11 (off), no register dependency causes a stall, a select or a branch stall; only R9 can stall.
- R4: For an ALU source matching only the memory-stage destination, forwarding mode (`mode_i`=2'b10) drives select 2'b10 (memory-stage value); stall-only mode (`mode_i`=2'b01) stalls.
- R5: For an ALU source matching the execute-stage destination, forwarding mode stalls if the execute instruction is a load and otherwise drives select 2'b01 (execute-stage ALU result); stall-only mode stalls.
- R6: When an ALU source matches both the execute and the memory destination, the execute-stage match decides the outcome.
- R7: In stall-only or forwarding mode, a branch source matching the execute-stage destination always raises both `stall_o` and `branch_stall_o`; `branch_stall_o` is never raised otherwise.
- R8: For a branch source matching only the memory-stage destination, the unit stalls in stall-only mode or when that instruction is a load; otherwise it raises the source's branch bypass bit (1 = take memory-stage value).
- R9: A serializing flag on the execute or memory instruction forces `stall_o` in every mode.
- R10: While `stall_o` is high, `pc_en_o` and `ifid_en_o` are low, `idex_bubble_o` is high and all selects and bypass bits are 0; while it is low, the enables are high and the bubble is low.
- R11: `stall_count_o` is 0 after reset and increases by one, modulo 2^CNT_W, at each clock edge where `stall_o` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| mode_i | input | 2 | 00/11 off, 01 stall-only, 10 stall-with-forwarding |
| dec_rs_i | input | RW | Decode first source register number |
| dec_rt_i | input | RW | Decode second source register number |
| dec_alu_rs_i | input | 1 | First source feeds the ALU |
| dec_alu_rt_i | input | 1 | Second source feeds the ALU |
| dec_br_rs_i | input | 1 | First source feeds the decode branch comparator |
| dec_br_rt_i | input | 1 | Second source feeds the decode branch comparator |
| ex_dst_i | input | RW | Execute-stage destination register |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| ex_serial_i | input | 1 | Execute-stage instruction is serializing |
| mem_dst_i | input | RW | Memory-stage destination register |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_serial_i | input | 1 | Memory-stage instruction is serializing |
| alu_sel_rs_o | output | 2 | First ALU operand source: 00 register file, 01 execute result, 10 memory value |
| alu_sel_rt_o | output | 2 | Second ALU operand source, same encoding |
| br_fwd_rs_o | output | 1 | Bypass memory-stage value into first branch operand |
| br_fwd_rt_o | output | 1 | Bypass memory-stage value into second branch operand |
| stall_o | output | 1 | Hold fetch and decode, bubble execute |
| branch_stall_o | output | 1 | Stall caused by a branch operand waiting on execute |
| pc_en_o | output | 1 | Program counter update enable |
| ifid_en_o | output | 1 | Fetch/decode pipeline register enable |
| idex_bubble_o | output | 1 | Replace the decode/execute register content by a bubble |
| stall_count_o | output | CNT_W | Number of stalled cycles since reset, wrapping |

## Verification
The properties assume the stage inputs are known and settled by each rising clock edge, and that a stage's load flag is only meaningful alongside its write enable; they make no assumption about register numbers or which need flags combine. The bench drives all inputs at the falling edge, draws register numbers from a small range so that execute and memory destinations frequently coincide with each other, with the decode sources and with register 0, and sweeps all four mode codes with directed vectors for each priority and mode corner, so every case the properties guard is reached with legal, stable inputs.

// File: rtl/hu_pkg.sv
package hu_pkg;

  typedef enum logic [1:0] {
    HM_OFF   = 2'b00,
    HM_STALL = 2'b01,
    HM_FWD   = 2'b10,
    HM_RSVD  = 2'b11
  } hu_mode_e;

  typedef enum logic [1:0] {
    FS_REGFILE = 2'b00,
    FS_EXEC    = 2'b01,
    FS_MEM     = 2'b10
  } fwd_src_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hu_match.sv
module hu_match #(
  parameter int unsigned RW = 5
) (
  input  logic [RW-1:0] dst,
  input  logic          wen,
  input  logic [RW-1:0] src,
  input  logic          need,
  output logic          hit
);
  logic dst_live;

  always_comb begin
    dst_live = wen && (dst != '0);
    hit      = dst_live && need && (dst == src);
  end
endmodule

// File: rtl/hu_operand.sv
module hu_operand
  import hu_pkg::*;
(
  input  hu_mode_e   mode,
  input  logic       ex_alu_hit,
  input  logic       mem_alu_hit,
  input  logic       ex_br_hit,
  input  logic       mem_br_hit,
  input  logic       ex_load,
  input  logic       mem_load,
  output logic [1:0] alu_sel,
  output logic       br_fwd,
  output logic       stall_req,
  output logic       br_stall_req
);
  logic handling;
  logic fwd_on;

  always_comb begin
    handling     = (mode == HM_STALL) || (mode == HM_FWD);
    fwd_on       = (mode == HM_FWD);
    alu_sel      = FS_REGFILE;
    br_fwd       = 1'b0;
    stall_req    = 1'b0;
    br_stall_req = 1'b0;
    if (handling) begin
      // ALU operand: execute stage has priority over memory stage
      if (ex_alu_hit) begin
        if (!fwd_on || ex_load) stall_req = 1'b1;
        else                    alu_sel   = FS_EXEC;
      end else if (mem_alu_hit) begin
        if (!fwd_on) stall_req = 1'b1;
        else         alu_sel   = FS_MEM;
      end
      // branch operand resolved in decode
      if (ex_br_hit) begin
        stall_req    = 1'b1;
        br_stall_req = 1'b1;
      end else if (mem_br_hit) begin
        if (!fwd_on || mem_load) stall_req = 1'b1;
        else                     br_fwd    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hu_stall_counter.sv
module hu_stall_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = inc;
    count_d  = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_q == $past(count_q) + CNT_W'($past(inc))));
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hu_pkg::*;
#(
  parameter int unsigned RW    = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic [RW-1:0]    dec_rs_i,
  input  logic [RW-1:0]    dec_rt_i,
  input  logic             dec_alu_rs_i,
  input  logic             dec_alu_rt_i,
  input  logic             dec_br_rs_i,
  input  logic             dec_br_rt_i,
  input  logic [RW-1:0]    ex_dst_i,
  input  logic             ex_wen_i,
  input  logic             ex_load_i,
  input  logic             ex_serial_i,
  input  logic [RW-1:0]    mem_dst_i,
  input  logic             mem_wen_i,
  input  logic             mem_load_i,
  input  logic             mem_serial_i,
  output logic [1:0]       alu_sel_rs_o,
  output logic [1:0]       alu_sel_rt_o,
  output logic             br_fwd_rs_o,
  output logic             br_fwd_rt_o,
  output logic             stall_o,
  output logic             branch_stall_o,
  output logic             pc_en_o,
  output logic             ifid_en_o,
  output logic             idex_bubble_o,
  output logic [CNT_W-1:0] stall_count_o
);
  hu_mode_e mode;
  assign mode = hu_mode_e'(mode_i);

  logic [RW-1:0]      src     [NUM_SRC];
  logic [NUM_SRC-1:0] alu_need;
  logic [NUM_SRC-1:0] br_need;
  logic [1:0]         sel_raw [NUM_SRC];
  logic [NUM_SRC-1:0] bfwd_raw;
  logic [NUM_SRC-1:0] stall_raw;
  logic [NUM_SRC-1:0] bstall_raw;

  assign src[0]   = dec_rs_i;
  assign src[1]   = dec_rt_i;
  assign alu_need = {dec_alu_rt_i, dec_alu_rs_i};
  assign br_need  = {dec_br_rt_i, dec_br_rs_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic ex_alu_hit, mem_alu_hit, ex_br_hit, mem_br_hit;

    hu_match #(.RW(RW)) u_ex_alu (
      .dst(ex_dst_i), .wen(ex_wen_i), .src(src[g]), .need(alu_need[g]), .hit(ex_alu_hit));
    hu_match #(.RW(RW)) u_mem_alu (
      .dst(mem_dst_i), .wen(mem_wen_i), .src(src[g]), .need(alu_need[g]), .hit(mem_alu_hit));
    hu_match #(.RW(RW)) u_ex_br (
      .dst(ex_dst_i), .wen(ex_wen_i), .src(src[g]), .need(br_need[g]), .hit(ex_br_hit));
    hu_match #(.RW(RW)) u_mem_br (
      .dst(mem_dst_i), .wen(mem_wen_i), .src(src[g]), .need(br_need[g]), .hit(mem_br_hit));

    hu_operand u_op (
      .mode        (mode),
      .ex_alu_hit  (ex_alu_hit),
      .mem_alu_hit (mem_alu_hit),
      .ex_br_hit   (ex_br_hit),
      .mem_br_hit  (mem_br_hit),
      .ex_load     (ex_load_i),
      .mem_load    (mem_load_i),
      .alu_sel     (sel_raw[g]),
      .br_fwd      (bfwd_raw[g]),
      .stall_req   (stall_raw[g]),
      .br_stall_req(bstall_raw[g])
    );
  end

  logic serial_hold;
  logic stall;

  always_comb begin
    serial_hold    = ex_serial_i || mem_serial_i;
    stall          = serial_hold || (|stall_raw);
    stall_o        = stall;
    branch_stall_o = |bstall_raw;
    alu_sel_rs_o   = stall ? FS_REGFILE : sel_raw[0];
    alu_sel_rt_o   = stall ? FS_REGFILE : sel_raw[1];
    br_fwd_rs_o    = !stall && bfwd_raw[0];
    br_fwd_rt_o    = !stall && bfwd_raw[1];
    pc_en_o        = !stall;
    ifid_en_o      = !stall;
    idex_bubble_o  = stall;
  end

  hu_stall_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (stall),
    .count(stall_count_o)
  );

  assert_zero_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst_i == '0 && mem_dst_i == '0 && !ex_serial_i && !mem_serial_i) |->
    (!stall_o && alu_sel_rs_o == 2'b00 && alu_sel_rt_o == 2'b00 && !br_fwd_rs_o && !br_fwd_rt_o));

  assert_off_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b00 || mode_i == 2'b11) && !ex_serial_i && !mem_serial_i) |->
    (!stall_o && !branch_stall_o && alu_sel_rs_o == 2'b00 && alu_sel_rt_o == 2'b00 &&
     !br_fwd_rs_o && !br_fwd_rt_o));

  assert_load_use_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && ex_wen_i && ex_load_i && ex_dst_i != '0 &&
     dec_alu_rs_i && dec_rs_i == ex_dst_i) |-> stall_o);

  assert_branch_ex_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b01 || mode_i == 2'b10) && ex_wen_i && ex_dst_i != '0 &&
     dec_br_rt_i && dec_rt_i == ex_dst_i) |-> (stall_o && branch_stall_o));

  assert_serial_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_serial_i || mem_serial_i) |-> stall_o);

  assert_bubble_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!pc_en_o && !ifid_en_o && idex_bubble_o && alu_sel_rs_o == 2'b00 &&
                 alu_sel_rt_o == 2'b00 && !br_fwd_rs_o && !br_fwd_rt_o));
endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW    = 5;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic [RW-1:0] rs, rt, exd, md;
  logic alur, alut, brs, brt, exw, exl, exs, mw, ml, ms;
  logic [1:0] sel_rs, sel_rt;
  logic bf_rs, bf_rt, stall, bstall, pc_en, ifid_en, bubble;
  logic [CNT_W-1:0] cnt;

  int n_checks = 0;
  int n_errors = 0;
  int mdl_cnt  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit #(.RW(RW), .CNT_W(CNT_W)) u_hazard_unit (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .dec_rs_i(rs), .dec_rt_i(rt), .dec_alu_rs_i(alur), .dec_alu_rt_i(alut),
    .dec_br_rs_i(brs), .dec_br_rt_i(brt),
    .ex_dst_i(exd), .ex_wen_i(exw), .ex_load_i(exl), .ex_serial_i(exs),
    .mem_dst_i(md), .mem_wen_i(mw), .mem_load_i(ml), .mem_serial_i(ms),
    .alu_sel_rs_o(sel_rs), .alu_sel_rt_o(sel_rt), .br_fwd_rs_o(bf_rs), .br_fwd_rt_o(bf_rt),
    .stall_o(stall), .branch_stall_o(bstall), .pc_en_o(pc_en), .ifid_en_o(ifid_en),
    .idex_bubble_o(bubble), .stall_count_o(cnt)
  );

  task automatic chk(string tag, string fld, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, fld, act, exp, $time);
    end
  endtask

  // behavioural reference: expected outputs from the requirement text
  int e_sel[2], e_bf[2], e_stall, e_bst;
  task automatic model();
    int srcs[2], need_a[2], need_b[2];
    bit handle, fwd;
    srcs[0] = rs; srcs[1] = rt;
    need_a[0] = alur; need_a[1] = alut;
    need_b[0] = brs;  need_b[1] = brt;
    handle = (mode == 1) || (mode == 2);
    fwd    = (mode == 2);
    e_stall = (exs || ms) ? 1 : 0;
    e_bst = 0;
    for (int i = 0; i < 2; i++) begin
      bit on_ex, on_mem;
      e_sel[i] = 0; e_bf[i] = 0;
      on_ex  = exw && exd != 0 && srcs[i] == exd;
      on_mem = mw  && md  != 0 && srcs[i] == md;
      if (!handle) continue;
      if (need_a[i] && on_ex) begin
        if (fwd && !exl) e_sel[i] = 1; else e_stall = 1;
      end else if (need_a[i] && on_mem) begin
        if (fwd) e_sel[i] = 2; else e_stall = 1;
      end
      if (need_b[i] && on_ex) begin
        e_stall = 1; e_bst = 1;
      end else if (need_b[i] && on_mem) begin
        if (fwd && !ml) e_bf[i] = 1; else e_stall = 1;
      end
    end
    if (e_stall) begin
      e_sel[0] = 0; e_sel[1] = 0; e_bf[0] = 0; e_bf[1] = 0;
    end
  endtask

  task automatic compare(string tag);
    model();
    chk(tag,   "alu_sel_rs", sel_rs, e_sel[0]);
    chk(tag,   "alu_sel_rt", sel_rt, e_sel[1]);
    chk(tag,   "br_fwd_rs",  bf_rs,  e_bf[0]);
    chk(tag,   "br_fwd_rt",  bf_rt,  e_bf[1]);
    chk(tag,   "stall",      stall,  e_stall);
    chk(tag,   "branch_stall", bstall, e_bst);
    chk("R10", "pc_en",      pc_en,  !e_stall);
    chk("R10", "ifid_en",    ifid_en, !e_stall);
    chk("R10", "bubble",     bubble, e_stall);
    chk("R11", "stall_count", cnt,   mdl_cnt);
  endtask

  task automatic apply(string tag, int m, int s1, int s2, bit a1, bit a2, bit b1, bit b2,
                       int xd, bit xw, bit xl, bit xs, int yd, bit yw, bit yl, bit ys);
    @(negedge clk);
    mode = 2'(m); rs = RW'(s1); rt = RW'(s2); alur = a1; alut = a2; brs = b1; brt = b2;
    exd = RW'(xd); exw = xw; exl = xl; exs = xs; md = RW'(yd); mw = yw; ml = yl; ms = ys;
    #1 compare(tag);
    @(posedge clk);
    if (rst_n) mdl_cnt = (mdl_cnt + e_stall) % (1 << CNT_W);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode = 0; rs = 0; rt = 0; alur = 0; alut = 0; brs = 0; brt = 0;
    exd = 0; exw = 0; exl = 0; exs = 0; md = 0; mw = 0; ml = 0; ms = 0;
    // R11 reset state, sampled while reset is held
    apply("R11", 2, 1, 2, 1, 1, 0, 0, 1, 1, 0, 0, 2, 1, 0, 0);
    apply("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: destination 0 ignored
    apply("R1", 2, 0, 0, 1, 1, 1, 1, 0, 1, 1, 0, 0, 1, 1, 0);
    apply("R1", 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, 0, 0, 1, 0, 0);
    // R2: need flag or write enable missing
    apply("R2", 1, 3, 3, 0, 0, 0, 0, 3, 1, 0, 0, 3, 1, 0, 0);
    apply("R2", 1, 3, 3, 1, 1, 1, 1, 3, 0, 1, 0, 3, 0, 1, 0);
    // R3: off mode, both codes
    apply("R3", 0, 4, 5, 1, 1, 1, 1, 4, 1, 1, 0, 5, 1, 1, 0);
    apply("R3", 3, 4, 5, 1, 1, 1, 1, 4, 1, 0, 0, 5, 1, 0, 0);
    // R4: memory-stage ALU hazard
    apply("R4", 2, 6, 1, 1, 0, 0, 0, 2, 1, 0, 0, 6, 1, 1, 0);
    apply("R4", 1, 6, 1, 1, 0, 0, 0, 2, 1, 0, 0, 6, 1, 0, 0);
    apply("R4", 2, 1, 6, 0, 1, 0, 0, 2, 1, 0, 0, 6, 1, 0, 0);
    // R5: execute-stage ALU hazard
    apply("R5", 2, 7, 1, 1, 0, 0, 0, 7, 1, 0, 0, 2, 1, 0, 0);
    apply("R5", 2, 7, 1, 1, 0, 0, 0, 7, 1, 1, 0, 2, 1, 0, 0);
    apply("R5", 1, 7, 1, 1, 0, 0, 0, 7, 1, 0, 0, 2, 1, 0, 0);
    // R6: execute wins over memory
    apply("R6", 2, 1, 9, 0, 1, 0, 0, 9, 1, 0, 0, 9, 1, 0, 0);
    apply("R6", 2, 9, 1, 1, 0, 0, 0, 9, 1, 1, 0, 9, 1, 0, 0);
    // R7: branch operand waiting on execute
    apply("R7", 2, 5, 8, 0, 0, 1, 1, 8, 1, 0, 0, 0, 0, 0, 0);
    apply("R7", 1, 5, 8, 0, 0, 1, 0, 5, 1, 0, 0, 0, 0, 0, 0);
    // R8: branch operand from memory stage
    apply("R8", 2, 5, 8, 0, 0, 1, 1, 1, 1, 0, 0, 5, 1, 0, 0);
    apply("R8", 2, 5, 8, 0, 0, 0, 1, 1, 1, 0, 0, 8, 1, 1, 0);
    apply("R8", 1, 5, 8, 0, 0, 1, 0, 1, 1, 0, 0, 5, 1, 0, 0);
    // R9: serializing instructions
    apply("R9", 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    apply("R9", 2, 1, 2, 1, 1, 0, 0, 1, 1, 0, 0, 2, 1, 0, 1);
    // R10/R11: random traffic, enables and wrapping counter checked every cycle
    for (int k = 0; k < 600; k++) begin
      apply("R2", $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom), ($urandom_range(0, 15) == 0));
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule